// File: doc/BRIEF.md
# Pack Current Protection Sequencer

This block is the autonomous current-protection sequencer of a battery pack controller. An analog front end supplies four digitized comparator flags: charge short circuit, discharge short circuit, charge overcurrent and discharge overload. The block checks how long each flag stays high against a programmable blanking window. The window is counted on a slow timebase tick derived from a 32.768 kHz clock. When a window runs out, the block latches the matching fault. It then pulls the charge and discharge gate enables low and turns the precharge gate enable on.

A host programs two configuration bytes, one holding the overcurrent and overload delay codes and one holding the short-circuit delay codes. It also drives FET request bits and a release bit. A latched fault clears only after the release bit has gone from 0 to 1 and back to 0. If the condition is still present once a FET conducts again, the block trips again. An active-low enable pin and a shutdown flag take priority over everything else.

The latch is a three-state machine. `ST_NORMAL` means no fault is held. `ST_LATCHED` holds a fault and waits for a rising edge of the release bit. `ST_ARMED` means the rising edge has been seen and the machine waits for the release bit to fall. The transitions are: NORMAL to LATCHED when any blanking window expires; LATCHED to ARMED when the release bit rises; ARMED to NORMAL when the release bit falls, which clears the flags.

Top module: `prot_seq_top`

## Requirements
- R1: After reset, with `enable_n` low, `shutdown` low and all host bits 0: `fault_flags` is 0, `chg_en` and `dsg_en` are 0, and `pchg_en` is 1.
- R2: Overcurrent and overload windows last 33 + 66*code ticks. The discharge overload code is `oc_delay_cfg[3:0]` and is flagged on `trip_raw[2]`. The charge overcurrent code is `oc_delay_cfg[7:4]` and is flagged on `trip_raw[3]`. With a tick on every clock, the fault latches on the (window+1)-th rising edge after the flag goes high.
- R3: Short-circuit windows last 2*code ticks. The discharge code is `sc_delay_cfg[3:0]` on `trip_raw[0]`; the charge code is `sc_delay_cfg[7:4]` on `trip_raw[1]`. Code 0 latches on the first rising edge at which the flag is seen high.
- R4: When a window expires, `fault_flags[i]` is set for condition i, `chg_en` and `dsg_en` go to 0, and `pchg_en` is 1, even if `host_pchg_off` is 1. This holds provided `enable_n` and `shutdown` are low.
- R5: Latched flags hold until `host_release` goes 0 then 1 then 0. Holding `host_release` at 1 does not clear them.
- R6: If the condition is still present after release and a main FET is enabled, the fault latches again on the next edge (code 0).
- R7: Each of the four conditions has its own counter. A counter restarts from zero whenever its flag drops before the window expires.
- R8: With no fault latched, `enable_n` low and `shutdown` low, `chg_en` follows `host_chg_on` and `dsg_en` follows `host_dsg_on`.
- R9: While `enable_n` is 1, all three enables are 0.
- R10: While `shutdown` is 1, all three enables are 0.
- R11: With no fault latched, `pchg_en` is 0 when `host_pchg_off` is 1.
- R12: No condition is evaluated while neither `chg_en` nor `dsg_en` is 1. Only the precharge path conducts then.
- R13: Window counters advance only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timebase strobe |
| trip_raw | input | 4 | Comparator flags: 0 short dsg, 1 short chg, 2 overload dsg, 3 overcurrent chg |
| oc_delay_cfg | input | 8 | Overcurrent/overload delay codes (low dsg, high chg) |
| sc_delay_cfg | input | 8 | Short-circuit delay codes (low dsg, high chg) |
| host_dsg_on | input | 1 | Host request for the discharge FET |
| host_chg_on | input | 1 | Host request for the charge FET |
| host_pchg_off | input | 1 | Host request to turn the precharge FET off |
| host_release | input | 1 | Latch release bit, pulsed 0-1-0 |
| enable_n | input | 1 | Active-low global gate enable |
| shutdown | input | 1 | Shutdown flag, forces all gates off |
| chg_en | output | 1 | Charge gate enable |
| dsg_en | output | 1 | Discharge gate enable |
| pchg_en | output | 1 | Precharge gate enable |
| fault_flags | output | 4 | Latched fault flags, same bit order as trip_raw |

## Verification
The checker watches a set of properties on every cycle. It checks that the main gates stay off whenever a flag is latched. It checks that the enable pin and shutdown turn every gate off, and that precharge is on during a fault. It checks that flags hold unless a release high phase has just ended. It also checks the immediate trip of a zero-code discharge short. The exact blanking lengths for each code and nibble, the counter restart, tick gating, re-tripping after release and the absence of evaluation on the precharge-only path can only be shown by the bench's timed scenarios.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;

    localparam int TRIP_N   = 4;
    localparam int CODE_W   = 4;
    localparam int OC_BASE  = 33;
    localparam int OC_STEP  = 66;
    localparam int SC_STEP  = 2;
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int CNT_W    = $clog2(OC_BASE + OC_STEP * CODE_MAX + 1);

    // trip index order, fixed because fault_flags bit positions follow it
    localparam int IDX_SC_DSG = 0;
    localparam int IDX_SC_CHG = 1;
    localparam int IDX_OC_DSG = 2;
    localparam int IDX_OC_CHG = 3;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_LATCHED = 2'd1,
        ST_ARMED   = 2'd2
    } latch_state_t;

endpackage

// File: rtl/prot_blank_timer.sv
module prot_blank_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = arm && (cnt_q >= limit);

endmodule

// File: rtl/prot_latch_fsm.sv
module prot_latch_fsm
    import prot_seq_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] expired,
    input  logic         release_bit,
    output logic [N-1:0] flags,
    output logic         latched
);

    latch_state_t state_q, state_d;
    logic [N-1:0] flags_q, flags_d;
    logic         release_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_NORMAL;
            flags_q   <= '0;
            release_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            flags_q   <= flags_d;
            release_q <= release_bit;
        end
    end

    // next state and flag update
    always_comb begin
        state_d = state_q;
        flags_d = flags_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (|expired) begin
                    state_d = ST_LATCHED;
                    flags_d = expired;
                end
            end
            ST_LATCHED: begin
                flags_d = flags_q | expired;
                if (release_bit && !release_q) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                flags_d = flags_q | expired;
                if (!release_bit) begin
                    state_d = ST_NORMAL;
                    flags_d = '0;
                end
            end
            default: begin
                state_d = ST_NORMAL;
                flags_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        flags   = flags_q;
        latched = (state_q != ST_NORMAL);
    end

endmodule

// File: rtl/prot_gate_ctl.sv
module prot_gate_ctl (
    input  logic latched,
    input  logic host_dsg_on,
    input  logic host_chg_on,
    input  logic host_pchg_off,
    input  logic enable_n,
    input  logic shutdown,
    output logic chg_en,
    output logic dsg_en,
    output logic pchg_en,
    output logic eval_on
);

    logic gates_allowed;

    always_comb begin
        gates_allowed = !enable_n && !shutdown;
        chg_en        = gates_allowed && !latched && host_chg_on;
        dsg_en        = gates_allowed && !latched && host_dsg_on;
        pchg_en       = gates_allowed && (latched || !host_pchg_off);
        eval_on       = chg_en || dsg_en;
    end

endmodule

// File: rtl/prot_seq_top.sv
module prot_seq_top
    import prot_seq_pkg::*;
#(
    parameter int N_TRIP = TRIP_N,
    parameter int CW     = CODE_W,
    parameter int CFG_W  = 2 * CODE_W,
    parameter int LIM_W  = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [N_TRIP-1:0] trip_raw,
    input  logic [CFG_W-1:0]  oc_delay_cfg,
    input  logic [CFG_W-1:0]  sc_delay_cfg,
    input  logic              host_dsg_on,
    input  logic              host_chg_on,
    input  logic              host_pchg_off,
    input  logic              host_release,
    input  logic              enable_n,
    input  logic              shutdown,
    output logic              chg_en,
    output logic              dsg_en,
    output logic              pchg_en,
    output logic [N_TRIP-1:0] fault_flags
);

    logic [N_TRIP-1:0] expired;
    logic              latched;
    logic              eval_on;

    for (genvar gi = 0; gi < N_TRIP; gi++) begin : g_cond
        logic [LIM_W-1:0] limit;
        logic [CW-1:0]    code;
        if (gi < 2) begin : g_short
            // short circuit: index 0 low nibble, index 1 high nibble
            assign code  = sc_delay_cfg[gi*CW +: CW];
            assign limit = LIM_W'(SC_STEP) * LIM_W'(code);
        end else begin : g_over
            // overcurrent/overload: index 2 low nibble, index 3 high nibble
            assign code  = oc_delay_cfg[(gi-2)*CW +: CW];
            assign limit = LIM_W'(OC_BASE) + LIM_W'(OC_STEP) * LIM_W'(code);
        end

        prot_blank_timer #(.CNT_W(LIM_W)) i_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .arm     (trip_raw[gi] && eval_on),
            .limit   (limit),
            .expired (expired[gi])
        );
    end

    prot_latch_fsm #(.N(N_TRIP)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .expired     (expired),
        .release_bit (host_release),
        .flags       (fault_flags),
        .latched     (latched)
    );

    prot_gate_ctl i_gate (
        .latched       (latched),
        .host_dsg_on   (host_dsg_on),
        .host_chg_on   (host_chg_on),
        .host_pchg_off (host_pchg_off),
        .enable_n      (enable_n),
        .shutdown      (shutdown),
        .chg_en        (chg_en),
        .dsg_en        (dsg_en),
        .pchg_en       (pchg_en),
        .eval_on       (eval_on)
    );

endmodule

// File: rtl/prot_seq_checker.sv
module prot_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] trip_raw,
    input logic [7:0] sc_delay_cfg,
    input logic       host_release,
    input logic       enable_n,
    input logic       shutdown,
    input logic       chg_en,
    input logic       dsg_en,
    input logic       pchg_en,
    input logic [3:0] fault_flags
);

    AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_flags) |-> (!chg_en && !dsg_en)); // R4

    AST_PCHG_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((|fault_flags) && !enable_n && !shutdown) |-> pchg_en); // R4

    AST_PIN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        enable_n |-> (!chg_en && !dsg_en && !pchg_en)); // R9

    AST_SHDN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (!chg_en && !dsg_en && !pchg_en)); // R10

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((|fault_flags) && !host_release && !$past(host_release)) |=> $stable(fault_flags)); // R5

    AST_SC0_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_raw[0] && (sc_delay_cfg[3:0] == 4'd0) && dsg_en) |=> fault_flags[0]); // R3

endmodule

bind prot_seq_top prot_seq_checker i_prot_seq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip_raw     (trip_raw),
    .sc_delay_cfg (sc_delay_cfg),
    .host_release (host_release),
    .enable_n     (enable_n),
    .shutdown     (shutdown),
    .chg_en       (chg_en),
    .dsg_en       (dsg_en),
    .pchg_en      (pchg_en),
    .fault_flags  (fault_flags)
);

// File: tb/test_prot_seq_top.sv
module test_prot_seq_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [3:0] trip_raw = '0;
    logic [7:0] oc_delay_cfg = '0;
    logic [7:0] sc_delay_cfg = '0;
    logic       host_dsg_on = 1'b0;
    logic       host_chg_on = 1'b0;
    logic       host_pchg_off = 1'b0;
    logic       host_release = 1'b0;
    logic       enable_n = 1'b0;
    logic       shutdown = 1'b0;
    logic       chg_en, dsg_en, pchg_en;
    logic [3:0] fault_flags;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_seq_top i_prot_seq_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .trip_raw      (trip_raw),
        .oc_delay_cfg  (oc_delay_cfg),
        .sc_delay_cfg  (sc_delay_cfg),
        .host_dsg_on   (host_dsg_on),
        .host_chg_on   (host_chg_on),
        .host_pchg_off (host_pchg_off),
        .host_release  (host_release),
        .enable_n      (enable_n),
        .shutdown      (shutdown),
        .chg_en        (chg_en),
        .dsg_en        (dsg_en),
        .pchg_en       (pchg_en),
        .fault_flags   (fault_flags)
    );

    // vector: {index[1:0], code[3:0], edges to trip[10:0]}
    localparam int NV = 10;
    localparam logic [16:0] VEC [NV] = '{
        {2'd0, 4'd0,  11'd1},
        {2'd0, 4'd3,  11'd7},
        {2'd1, 4'd0,  11'd1},
        {2'd1, 4'd15, 11'd31},
        {2'd2, 4'd0,  11'd34},
        {2'd2, 4'd1,  11'd100},
        {2'd3, 4'd0,  11'd34},
        {2'd3, 4'd2,  11'd166},
        {2'd2, 4'd15, 11'd1024},
        {2'd3, 4'd15, 11'd1024}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_pulse();
        host_release = 1'b1;
        cyc(1);
        host_release = 1'b0;
        cyc(1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 faults", fault_flags, 0);
        chk("R1 chg", chg_en, 0);
        chk("R1 dsg", dsg_en, 0);
        chk("R1 pchg", pchg_en, 1);

        // R8 host bits followed
        host_chg_on = 1'b1;
        cyc(1);
        chk("R8 chg", chg_en, 1);
        chk("R8 dsg", dsg_en, 0);
        host_chg_on = 1'b0;
        host_dsg_on = 1'b1;
        cyc(1);
        chk("R8 chg off", chg_en, 0);
        chk("R8 dsg", dsg_en, 1);

        // R11 precharge off by host
        host_pchg_off = 1'b1;
        cyc(1);
        chk("R11 pchg", pchg_en, 0);
        host_pchg_off = 1'b0;
        host_chg_on = 1'b1;

        // table walk over R2 and R3 windows
        for (int v = 0; v < NV; v++) begin
            int idx;
            int code;
            int edges;
            idx   = int'(VEC[v][16:15]);
            code  = int'(VEC[v][14:11]);
            edges = int'(VEC[v][10:0]);
            oc_delay_cfg = 8'hFF;
            sc_delay_cfg = 8'hFF;
            if (idx < 2) sc_delay_cfg[idx*4 +: 4] = 4'(code);
            else         oc_delay_cfg[(idx-2)*4 +: 4] = 4'(code);
            trip_raw[idx] = 1'b1;
            cyc(edges - 1);
            chk((idx < 2) ? "R3 before window" : "R2 before window", fault_flags, 0);
            cyc(1);
            chk((idx < 2) ? "R3 trip flag" : "R2 trip flag", fault_flags, 1 << idx);
            chk("R4 gates off", {chg_en, dsg_en}, 0);
            chk("R4 pchg on", pchg_en, 1);
            trip_raw = '0;
            release_pulse();
            chk("R5 cleared", fault_flags, 0);
            chk("R5 dsg back", dsg_en, 1);
        end

        // R7 restart after drop (overload, code 0, window 33)
        oc_delay_cfg = 8'h00;
        trip_raw[2] = 1'b1;
        cyc(20);
        trip_raw[2] = 1'b0;
        cyc(1);
        trip_raw[2] = 1'b1;
        cyc(33);
        chk("R7 no trip after restart", fault_flags, 0);
        cyc(1);
        chk("R7 trip after full window", fault_flags, 4);

        // R4 precharge forced on in fault despite host off
        host_pchg_off = 1'b1;
        cyc(1);
        chk("R4 pchg forced", pchg_en, 1);
        host_pchg_off = 1'b0;

        // R5 holding release high does not clear
        trip_raw = '0;
        host_release = 1'b1;
        cyc(5);
        chk("R5 held high", fault_flags, 4);
        host_release = 1'b0;
        cyc(1);
        chk("R5 full pulse clears", fault_flags, 0);

        // R13 no progress without tick (short dsg code 1, window 2)
        sc_delay_cfg = 8'h01;
        tick = 1'b0;
        trip_raw[0] = 1'b1;
        cyc(10);
        chk("R13 no tick no trip", fault_flags, 0);
        tick = 1'b1;
        cyc(2);
        chk("R13 before window", fault_flags, 0);
        cyc(1);
        chk("R13 trip with ticks", fault_flags, 1);
        trip_raw = '0;
        release_pulse();

        // R12 precharge-only path: no evaluation
        sc_delay_cfg = 8'h00;
        host_chg_on = 1'b0;
        host_dsg_on = 1'b0;
        trip_raw[0] = 1'b1;
        cyc(5);
        chk("R12 no trip", fault_flags, 0);
        chk("R12 pchg on", pchg_en, 1);
        host_dsg_on = 1'b1;
        cyc(1);
        chk("R12 trip once enabled", fault_flags, 1);

        // R6 retrip with persistent condition
        host_release = 1'b1;
        cyc(1);
        host_release = 1'b0;
        cyc(1);
        chk("R6 released", fault_flags, 0);
        chk("R6 dsg on", dsg_en, 1);
        cyc(1);
        chk("R6 retrip", fault_flags, 1);
        trip_raw = '0;
        release_pulse();

        // R9 enable pin
        host_chg_on = 1'b1;
        enable_n = 1'b1;
        cyc(1);
        chk("R9 all off", {chg_en, dsg_en, pchg_en}, 0);
        enable_n = 1'b0;

        // R10 shutdown
        shutdown = 1'b1;
        cyc(1);
        chk("R10 all off", {chg_en, dsg_en, pchg_en}, 0);
        shutdown = 1'b0;
        cyc(1);
        chk("R8 restored", {chg_en, dsg_en, pchg_en}, 7);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule